// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects interrupt events from up to 32 hardware sources into a sticky cause register and drives one interrupt line towards the host. Every source owns one bit position, and that position is the same in every register of the group. Software reaches the group over a simple register bus with one-cycle accesses. It sets the clear policy for each bit, reads the raw or the masked cause, injects causes for test, and masks or unmasks sources. It can change the mask as a whole word or through separate set and clear aliases, which need no read-modify-write.

A source is recorded when its event input rises. The clear policy of each bit is chosen at run time. In write-one-to-clear mode a bit is cleared by writing a 1 to it. In clear-on-read mode a bit is cleared by reading it. The same policy applies whether software goes through the raw cause word or through the masked view. The interrupt line is the registered OR of all unmasked pending causes.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the cause word is zero, the mask word is all ones, every bit is in write-one-to-clear mode and `irq_out` is low.
- R2: Word offset 0 holds the per-bit clear mode (0 = write-one-to-clear, 1 = clear-on-read) and offset 4 holds the mask value. Both can be read and written directly.
- R3: A read at offset 2 returns the cause word with every bit that has a mask bit of 1 forced to zero.
- R4: For a bit in write-one-to-clear mode, writing 1 at offset 1 clears the cause bit and writing 0 leaves it alone. Reads at offset 1 do not change it.
- R5: For a bit in clear-on-read mode, a read at offset 1 returns the cause bit and then clears it. Writes at offset 1 have no effect on that bit.
- R6: Offset 2 clears the cause through the masked view under the same per-bit mode. A 1 written there clears only unmasked write-one-to-clear bits. A read there clears only the unmasked clear-on-read bits that it returned. Masked bits keep their cause.
- R7: Writing 1 at offset 3 sets that cause bit, and zeros there change nothing. Reads at offsets 3, 5, 6 and 7 return zero.
- R8: A 1 written at offset 5 sets that mask bit. A 1 written at offset 6 clears that mask bit. Zeros in either write leave the mask unchanged.
- R9: A cause bit is set when its `evt_in` bit goes from 0 to 1. A level that stays high does not set the bit again after it has been cleared.
- R10: When a set (event rise or offset-3 write) and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: On a clear-on-read access, only the bits returned as 1 by that read are cleared. An event that rises in the same cycle stays pending for the next read.
- R12: `irq_out` is high exactly one clock after a cycle in which some cause bit is set while its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 32 | Hardware event levels, one per source; a rising edge records a cause |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register in the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle; zero when no read is selected |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions. One is an event edge that arrives on the exact clock in which software clears that bit by a write. The other is an edge that arrives during a clear-on-read access, including on a bit that the read did not return. The stimulus drives the event vector and the bus access inside one cycle window, so both land on the same clock edge. Reads follow at once to show the bit still pending. Clears through the masked view are also exercised with a mix of masked and unmasked pending bits in both modes. The reference model then compares every cycle to confirm that the masked bits survive.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned ADDR_W = 3;

    // Word offsets inside the group; the sequence is part of the programming model.
    typedef enum logic [ADDR_W-1:0] {
        OFS_MODE   = 3'd0,
        OFS_CAUSE  = 3'd1,
        OFS_MASKED = 3'd2,
        OFS_SET    = 3'd3,
        OFS_MASK   = 3'd4,
        OFS_MSET   = 3'd5,
        OFS_MCLR   = 3'd6,
        OFS_SPARE  = 3'd7
    } reg_ofs_e;

    // One strobe per register action, decoded from a single bus access.
    typedef struct packed {
        logic wr_mode;
        logic wr_cause;
        logic rd_cause;
        logic wr_masked;
        logic rd_masked;
        logic wr_set;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
    } bus_strobe_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_bank_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_strobe_t       stb
);

    always_comb begin
        stb = '0;
        if (bus_sel) begin
            unique case (reg_ofs_e'(bus_addr))
                OFS_MODE:   stb.wr_mode   = bus_wr;
                OFS_CAUSE: begin
                    stb.wr_cause = bus_wr;
                    stb.rd_cause = !bus_wr;
                end
                OFS_MASKED: begin
                    stb.wr_masked = bus_wr;
                    stb.rd_masked = !bus_wr;
                end
                OFS_SET:    stb.wr_set    = bus_wr;
                OFS_MASK:   stb.wr_mask   = bus_wr;
                OFS_MSET:   stb.wr_mset   = bus_wr;
                OFS_MCLR:   stb.wr_mclr   = bus_wr;
                default:    stb           = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = evt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = evt_in & ~prev_q;

endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core
    import irq_bank_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bus_strobe_t  stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rise,
    output logic [W-1:0] mode_o,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] cause;
        logic [W-1:0] mask;
        logic         irq;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] set_vec;

    // Per-bit clear and set decisions.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic open_b;
        logic w1c_hit;
        logic cor_hit;
        assign open_b  = ~st_q.mask[b];
        // write-one-to-clear: raw view always, masked view only when unmasked
        assign w1c_hit = ~st_q.mode[b] & wdata[b]
                       & (stb.wr_cause | (stb.wr_masked & open_b));
        // clear-on-read: only a bit that this read returns as 1
        assign cor_hit = st_q.mode[b] & st_q.cause[b]
                       & (stb.rd_cause | (stb.rd_masked & open_b));
        assign clr_vec[b] = w1c_hit | cor_hit;
        assign set_vec[b] = (stb.wr_set & wdata[b]) | rise[b];
    end

    always_comb begin
        st_d = st_q;
        if (stb.wr_mode) st_d.mode = wdata;
        if (stb.wr_mask)      st_d.mask = wdata;
        else if (stb.wr_mset) st_d.mask = st_q.mask | wdata;
        else if (stb.wr_mclr) st_d.mask = st_q.mask & ~wdata;
        // set has priority over any clear on the same bit
        st_d.cause = set_vec | (st_q.cause & ~clr_vec);
        st_d.irq   = |(st_q.cause & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= '0;
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_out
);

    bus_strobe_t  stb;
    logic [W-1:0] rise_vec;
    logic [W-1:0] mode_vec;
    logic [W-1:0] cause_vec;
    logic [W-1:0] mask_vec;

    irq_bus_decode u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .stb      (stb)
    );

    irq_edge_detect #(.W(W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .rise   (rise_vec)
    );

    irq_cause_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .wdata   (bus_wdata),
        .rise    (rise_vec),
        .mode_o  (mode_vec),
        .cause_o (cause_vec),
        .mask_o  (mask_vec),
        .irq_o   (irq_out)
    );

    // Read data in the access cycle; clears take effect at the closing edge.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_ofs_e'(bus_addr))
                OFS_MODE:   bus_rdata = mode_vec;
                OFS_CAUSE:  bus_rdata = cause_vec;
                OFS_MASKED: bus_rdata = cause_vec & ~mask_vec;
                OFS_MASK:   bus_rdata = mask_vec;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] cause_vec,
    input logic [W-1:0] mask_vec,
    input logic [W-1:0] mode_vec,
    input logic [W-1:0] rise_vec,
    input logic         irq_out
);

    logic [W-1:0] set_req;
    logic         rd_raw, rd_view, rd_zero, wr_mset, wr_mclr;

    assign set_req = rise_vec | ((bus_sel && bus_wr && bus_addr == 3'd3) ? bus_wdata : '0);
    assign rd_raw  = bus_sel && !bus_wr && bus_addr == 3'd1;
    assign rd_view = bus_sel && !bus_wr && bus_addr == 3'd2;
    assign rd_zero = bus_sel && !bus_wr && (bus_addr == 3'd3 || bus_addr >= 3'd5);
    assign wr_mset = bus_sel && bus_wr && bus_addr == 3'd5;
    assign wr_mclr = bus_sel && bus_wr && bus_addr == 3'd6;

    // R12: registered OR of unmasked pending causes
    p_irq_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|(cause_vec & ~mask_vec)));

    // R10: every requested set is present after the edge
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req != '0) |=> ((cause_vec & $past(set_req)) == $past(set_req)));

    // R9: a cause bit never appears without a set request
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_vec & ~$past(cause_vec) & ~$past(set_req)) == '0));

    // R8: mask set and clear aliases
    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_vec & $past(bus_wdata)) == $past(bus_wdata)));
    p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_vec & $past(bus_wdata)) == '0));

    // R7: write-only and unused offsets read as zero
    p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> bus_rdata == '0);

    // R3: masked view never shows a masked bit
    p_view_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_view |-> ((bus_rdata & mask_vec) == '0));

    // R5: clear-on-read bits returned by a raw read are gone unless set again
    p_cor_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_raw |=> ((cause_vec & $past(bus_rdata & mode_vec & ~set_req)) == '0));

    // R4: a raw read keeps write-one-to-clear bits
    p_w1c_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_raw |=> ((cause_vec & $past(cause_vec & ~mode_vec)) == $past(cause_vec & ~mode_vec)));

endmodule

bind irq_cause_bank irq_cause_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cause_vec (cause_vec),
    .mask_vec  (mask_vec),
    .mode_vec  (mode_vec),
    .rise_vec  (rise_vec),
    .irq_out   (irq_out)
);

// File: tb/irq_cause_bank_tb_top.sv
module irq_cause_bank_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_in = '0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq_out;

    always #4 clk = ~clk;   // 125 MHz

    irq_cause_bank #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    logic [W-1:0] evt_lvl = '0;

    // ---------------- behavioural reference model ----------------
    logic [W-1:0] m_mode, m_cause, m_mask, m_prev;
    logic         m_irq;

    always @(posedge clk or negedge rst_n) begin : mdl
        logic [W-1:0] nc;
        logic         shown;
        if (!rst_n) begin
            m_mode  <= '0;
            m_cause <= '0;
            m_mask  <= '1;
            m_prev  <= '0;
            m_irq   <= 1'b0;
        end else begin
            nc = m_cause;
            for (int b = 0; b < W; b++) begin
                shown = m_cause[b] && !m_mask[b];
                if (bus_sel && !bus_wr && m_mode[b]) begin
                    if (bus_addr == 3'd1 && m_cause[b]) nc[b] = 1'b0;
                    if (bus_addr == 3'd2 && shown)      nc[b] = 1'b0;
                end
                if (bus_sel && bus_wr && !m_mode[b] && bus_wdata[b]) begin
                    if (bus_addr == 3'd1)                nc[b] = 1'b0;
                    if (bus_addr == 3'd2 && !m_mask[b])  nc[b] = 1'b0;
                end
                if (bus_sel && bus_wr && bus_addr == 3'd3 && bus_wdata[b]) nc[b] = 1'b1;
                if (evt_in[b] && !m_prev[b]) nc[b] = 1'b1;
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    3'd0: m_mode <= bus_wdata;
                    3'd4: m_mask <= bus_wdata;
                    3'd5: m_mask <= m_mask | bus_wdata;
                    3'd6: m_mask <= m_mask & ~bus_wdata;
                    default: ;
                endcase
            end
            m_irq   <= (m_cause & ~m_mask) != '0;
            m_cause <= nc;
            m_prev  <= evt_in;
        end
    end

    function automatic logic [W-1:0] model_rdata();
        if (!bus_sel || bus_wr) return '0;
        case (bus_addr)
            3'd0: return m_mode;
            3'd1: return m_cause;
            3'd2: return m_cause & ~m_mask;
            3'd4: return m_mask;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd4: return "R2";
            3'd1:       return "R4";
            3'd2:       return "R3";
            default:    return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(tag_of(bus_addr), bus_rdata, model_rdata());
            chk("R12", W'(irq_out), W'(m_irq));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic s, input logic w, input logic [2:0] a, input logic [W-1:0] d);
        @(posedge clk);
        #2;
        bus_sel   = s;
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
        evt_in    = evt_lvl;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 3'd0, '0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        drive(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
        drive(1'b1, 1'b0, a, '0);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp);
        idle();
        idle();
        @(negedge clk);
        chk("R12", W'(irq_out), W'(exp));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 32'h0, "R1");
        rd_chk(3'd1, 32'h0, "R1");
        rd_chk(3'd4, 32'hFFFF_FFFF, "R1");
        @(negedge clk);
        chk("R1", W'(irq_out), '0);

        // R2 mask value read/write
        wr(3'd4, 32'h0);
        rd_chk(3'd4, 32'h0, "R2");

        // R7 cause set and write-only reads
        wr(3'd3, 32'h0000_0F0F);
        rd_chk(3'd3, 32'h0, "R7");
        rd_chk(3'd5, 32'h0, "R7");
        rd_chk(3'd1, 32'h0000_0F0F, "R7");
        irq_chk(1'b1);

        // R8 mask aliases, R3 masked view
        wr(3'd5, 32'h0000_000F);
        rd_chk(3'd2, 32'h0000_0F00, "R3");
        wr(3'd6, 32'h0000_0003);
        rd_chk(3'd4, 32'h0000_000C, "R8");
        rd_chk(3'd2, 32'h0000_0F03, "R3");

        // R4 write-one-to-clear on raw cause
        wr(3'd1, 32'h0000_0001);
        rd_chk(3'd1, 32'h0000_0F0E, "R4");
        rd_chk(3'd1, 32'h0000_0F0E, "R4");

        // R2 clear-mode register
        wr(3'd0, 32'h0000_FF00);
        rd_chk(3'd0, 32'h0000_FF00, "R2");

        // R5 clear-on-read on raw cause, writes ignored
        wr(3'd1, 32'h0000_0100);
        rd_chk(3'd1, 32'h0000_0F0E, "R5");
        rd_chk(3'd1, 32'h0000_000E, "R5");

        // R6 clears through the masked view
        wr(3'd3, 32'h0000_0F01);
        wr(3'd2, 32'h0000_000F);
        rd_chk(3'd2, 32'h0000_0F00, "R6");
        rd_chk(3'd1, 32'h0000_000C, "R6");
        wr(3'd3, 32'h0000_0200);
        wr(3'd5, 32'h0000_0200);
        rd_chk(3'd2, 32'h0, "R6");
        rd_chk(3'd1, 32'h0000_020C, "R6");
        rd_chk(3'd1, 32'h0000_000C, "R5");

        // R12 mask gates the interrupt line
        irq_chk(1'b0);
        wr(3'd6, 32'h0000_0004);
        irq_chk(1'b1);
        wr(3'd1, 32'h0000_000C);
        irq_chk(1'b0);

        // R9 rising edge only
        evt_lvl = 32'h0000_0010;
        idle();
        rd_chk(3'd1, 32'h0000_0010, "R9");
        wr(3'd1, 32'h0000_0010);
        idle();
        rd_chk(3'd1, 32'h0, "R9");
        evt_lvl = '0;
        idle();

        // R10 event rise beats a same-cycle clear
        wr(3'd3, 32'h0000_0020);
        evt_lvl = 32'h0000_0020;
        wr(3'd1, 32'h0000_0020);
        rd_chk(3'd1, 32'h0000_0020, "R10");
        wr(3'd1, 32'h0000_0020);
        rd_chk(3'd1, 32'h0, "R10");
        evt_lvl = '0;
        idle();

        // R11 events arriving during a clear-on-read stay pending
        wr(3'd3, 32'h0000_0400);
        evt_lvl = 32'h0000_0C00;
        rd_chk(3'd1, 32'h0000_0400, "R11");
        rd_chk(3'd1, 32'h0000_0C00, "R11");
        rd_chk(3'd1, 32'h0, "R11");
        evt_lvl = '0;
        idle();
        idle();

        finish_run();
    end

endmodule